// File: doc/BRIEF.md
# Half-Span Fractional-N Delay and Polarity Controller

This block runs once per reference cycle in a fractional-N synthesizer whose ring oscillator is realigned to a clean reference edge each cycle. It takes a frequency control word, split into an integer divide value and a fraction. From that word it produces three things: a divide modulus that dithers between N and N+1, a delay word for a digital-to-time converter, and a polarity-swap flag. The delay word only ever has to span half an oscillator period.

The fraction is requantized in two stages. The first stage is a first-order error-feedback accumulator. It works on every fraction bit below the most significant one, and it sees the fraction doubled. Its carry, halved back to the original weight, is added with the fraction's top bit into a one-bit modulo-2 accumulator. The carry of that modulo-2 accumulator steps the divider. Its stored bit is the swap flag, which is high while the fractional phase lies in the second half of the period. The residue of the first stage, scaled by a programmable gain and offset by an external duty-cycle correction, becomes the saturated delay word.

The same swap flag fixes the sign of a one-bit phase-detector sample. The corrected sample drives a proportional-integral fine-tuning word for the oscillator.

Top module: `halfspan_dtc_ctrl`

## Requirements
- R1: While rst is high at a clock edge, every output register goes to zero on that edge: div_mod, swap, dtc_word and tune_word. The internal phase and the integrator are also cleared.
- R2: On each strobe, div_mod becomes fcw_int plus the carry of an accumulator that adds fcw_frac modulo 2^FRAC_W. Over any 2^FRAC_W consecutive strobes with a fixed fraction, the carries sum to exactly fcw_frac.
- R3: After a strobe, swap equals the most significant bit of that fraction phase. A value of 1 means the phase is at or above one half.
- R4: After a strobe, dtc_word equals floor(r*gain / 2^(FRAC_W-1)) + dcc, clamped to the range 0 to 2^DTC_W-1. Here r is the fraction phase without its top bit and dcc is a signed two's-complement value. The delay term therefore always stays below one half-period's worth of gain.
- R5: On a strobe, the phase-error direction is positive when pd_sample XOR swap is 1 and negative otherwise. The swap value used is the one presented on the output before that strobe.
- R6: On a strobe, the integrator moves by +ki or -ki in that direction and saturates to the signed TUNE_W range. tune_word becomes the saturated sum of the new integrator value and +kp or -kp.
- R7: With valid low, no output changes.
- R8: A strobe with fcw_frac equal to zero leaves swap unchanged and sets div_mod to exactly fcw_int.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | Per-reference-cycle advance strobe |
| fcw_int | input | INT_W | Integer part N of the control word |
| fcw_frac | input | FRAC_W | Fractional part of the control word |
| gain | input | GAIN_W | Unsigned residue-to-delay gain |
| dcc | input | DCC_W | Signed duty-cycle correction added to the delay |
| pd_sample | input | 1 | One-bit phase-detector sample |
| kp | input | KG_W | Unsigned proportional gain |
| ki | input | KG_W | Unsigned integral gain |
| div_mod | output | INT_W+1 | Divider modulus, N or N+1 |
| swap | output | 1 | Injection polarity-swap flag |
| dtc_word | output | DTC_W | Saturated delay-converter word |
| tune_word | output | TUNE_W | Signed oscillator fine-tune word |

## Verification
The bench builds the block with a 6-bit fraction, a 6-bit gain, a 5-bit delay word, a 4-bit correction, an 8-bit tune word and 4-bit loop gains. At these sizes it can sweep all 64 fraction values, each for a full 64-strobe period, so the carry count per period and every phase position are checked exactly. The gain, the correction and the phase-detector sample vary together. This drives the delay word into both clamps and drives the 8-bit integrator into both of its rails.

// File: rtl/halfspan_pkg.sv
package halfspan_pkg;
  typedef enum logic {ERR_NEG = 1'b0, ERR_POS = 1'b1} err_dir_t;

  function automatic err_dir_t err_dir(input logic sample, input logic flip);
    return err_dir_t'(sample ^ flip);
  endfunction
endpackage

// File: rtl/halfspan_requant.sv
module halfspan_requant #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-2:0] resid_n,
  output logic              swap_n,
  output logic              carry_n,
  output logic              swap_q
);
  localparam int LW = FRAC_W - 1;

  logic [LW-1:0] resid_q;
  logic [LW:0]   sum1;
  logic          c1;
  logic [1:0]    half_units;
  logic [1:0]    sum2;

  always_comb begin
    // stage one: lower fraction bits seen doubled, carry is the coarse output
    sum1       = {1'b0, resid_q} + {1'b0, frac[LW-1:0]};
    c1         = sum1[LW];
    resid_n    = sum1[LW-1:0];
    // halve back: count of half-periods this cycle (fraction MSB plus carry)
    half_units = {1'b0, frac[FRAC_W-1]} + {1'b0, c1};
    // modulo-2 stage
    sum2       = {1'b0, swap_q} + half_units;
    carry_n    = sum2[1];
    swap_n     = sum2[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resid_q <= '0;
      swap_q  <= 1'b0;
    end else if (adv) begin
      resid_q <= resid_n;
      swap_q  <= swap_n;
    end
  end
endmodule

// File: rtl/halfspan_dtc_scale.sv
module halfspan_dtc_scale #(
  parameter int RES_W  = 15,
  parameter int GAIN_W = 12,
  parameter int DCC_W  = 8,
  parameter int DTC_W  = 10
) (
  input  logic [RES_W-1:0]        resid,
  input  logic [GAIN_W-1:0]       gain,
  input  logic signed [DCC_W-1:0] dcc,
  output logic [DTC_W-1:0]        word
);
  localparam int PW  = RES_W + GAIN_W;
  localparam int MX1 = (GAIN_W > DCC_W) ? GAIN_W : DCC_W;
  localparam int SW  = ((MX1 > DTC_W) ? MX1 : DTC_W) + 2;

  logic [PW-1:0]        prod;
  logic [GAIN_W-1:0]    scaled;
  logic signed [SW-1:0] total;
  logic signed [SW-1:0] top;

  always_comb begin
    prod   = PW'(resid) * PW'(gain);
    scaled = prod[PW-1:RES_W];
    total  = $signed({{(SW-GAIN_W){1'b0}}, scaled}) + $signed({{(SW-DCC_W){dcc[DCC_W-1]}}, dcc});
    top    = $signed({{(SW-DTC_W){1'b0}}, {DTC_W{1'b1}}});
    if (total < 0)        word = '0;
    else if (total > top) word = {DTC_W{1'b1}};
    else                  word = total[DTC_W-1:0];
  end
endmodule

// File: rtl/halfspan_fine_tune.sv
module halfspan_fine_tune
  import halfspan_pkg::*;
#(
  parameter int TUNE_W = 16,
  parameter int KG_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     adv,
  input  logic                     sample,
  input  logic                     flip,
  input  logic [KG_W-1:0]          kp,
  input  logic [KG_W-1:0]          ki,
  output logic signed [TUNE_W-1:0] tune_q
);
  localparam int EW = ((KG_W > TUNE_W) ? KG_W : TUNE_W) + 2;

  logic signed [TUNE_W-1:0] integ_q, integ_n, tune_n;
  logic signed [EW-1:0]     ki_e, kp_e, isum, tsum;
  err_dir_t                 dir;

  function automatic logic signed [TUNE_W-1:0] clamp(input logic signed [EW-1:0] v);
    logic signed [EW-1:0] hi, lo;
    hi = $signed({{(EW-TUNE_W+1){1'b0}}, {(TUNE_W-1){1'b1}}});
    lo = -hi - 1;
    if (v > hi)      return hi[TUNE_W-1:0];
    else if (v < lo) return lo[TUNE_W-1:0];
    else             return v[TUNE_W-1:0];
  endfunction

  always_comb begin
    dir     = err_dir(sample, flip);
    ki_e    = $signed({{(EW-KG_W){1'b0}}, ki});
    kp_e    = $signed({{(EW-KG_W){1'b0}}, kp});
    isum    = EW'(integ_q) + ((dir == ERR_POS) ? ki_e : -ki_e);
    integ_n = clamp(isum);
    tsum    = EW'(integ_n) + ((dir == ERR_POS) ? kp_e : -kp_e);
    tune_n  = clamp(tsum);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      tune_q  <= '0;
    end else if (adv) begin
      integ_q <= integ_n;
      tune_q  <= tune_n;
    end
  end
endmodule

// File: rtl/halfspan_dtc_ctrl.sv
module halfspan_dtc_ctrl #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int GAIN_W = 12,
  parameter int DCC_W  = 8,
  parameter int DTC_W  = 10,
  parameter int TUNE_W = 16,
  parameter int KG_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic [INT_W-1:0]         fcw_int,
  input  logic [FRAC_W-1:0]        fcw_frac,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [DCC_W-1:0]  dcc,
  input  logic                     pd_sample,
  input  logic [KG_W-1:0]          kp,
  input  logic [KG_W-1:0]          ki,
  output logic [INT_W:0]           div_mod,
  output logic                     swap,
  output logic [DTC_W-1:0]         dtc_word,
  output logic signed [TUNE_W-1:0] tune_word
);
  localparam int RES_W = FRAC_W - 1;

  logic [RES_W-1:0] resid_n;
  logic             swap_n, carry_n;
  logic [DTC_W-1:0] dtc_n;

  halfspan_requant #(.FRAC_W(FRAC_W)) u_requant (
    .clk(clk), .rst(rst), .adv(valid), .frac(fcw_frac),
    .resid_n(resid_n), .swap_n(swap_n), .carry_n(carry_n), .swap_q(swap)
  );

  halfspan_dtc_scale #(.RES_W(RES_W), .GAIN_W(GAIN_W), .DCC_W(DCC_W), .DTC_W(DTC_W)) u_scale (
    .resid(resid_n), .gain(gain), .dcc(dcc), .word(dtc_n)
  );

  halfspan_fine_tune #(.TUNE_W(TUNE_W), .KG_W(KG_W)) u_tune (
    .clk(clk), .rst(rst), .adv(valid), .sample(pd_sample), .flip(swap),
    .kp(kp), .ki(ki), .tune_q(tune_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div_mod  <= '0;
      dtc_word <= '0;
    end else if (valid) begin
      div_mod  <= {1'b0, fcw_int} + {{INT_W{1'b0}}, carry_n};
      dtc_word <= dtc_n;
    end
  end
endmodule

// File: rtl/halfspan_dtc_ctrl_chk.sv
module halfspan_dtc_ctrl_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int GAIN_W = 12,
  parameter int DCC_W  = 8,
  parameter int DTC_W  = 10,
  parameter int TUNE_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     valid,
  input logic [INT_W-1:0]         fcw_int,
  input logic [FRAC_W-1:0]        fcw_frac,
  input logic [GAIN_W-1:0]        gain,
  input logic signed [DCC_W-1:0]  dcc,
  input logic [INT_W:0]           div_mod,
  input logic                     swap,
  input logic [DTC_W-1:0]         dtc_word,
  input logic signed [TUNE_W-1:0] tune_word
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (div_mod == '0 && !swap && dtc_word == '0 && tune_word == '0));

  p_mod_range_r2: assert property (@(posedge clk) disable iff (rst)
    valid |=> (div_mod == {1'b0, $past(fcw_int)} || div_mod == {1'b0, $past(fcw_int)} + 1'b1));

  p_zero_delay_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && gain == '0 && dcc == '0) |=> dtc_word == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(div_mod) && $stable(swap) && $stable(dtc_word) && $stable(tune_word)));

  p_zero_frac_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && fcw_frac == '0) |=> (swap == $past(swap) && div_mod == {1'b0, $past(fcw_int)}));
endmodule

bind halfspan_dtc_ctrl halfspan_dtc_ctrl_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W),
  .DCC_W(DCC_W), .DTC_W(DTC_W), .TUNE_W(TUNE_W)
) u_chk (.*);

// File: tb/tb_halfspan_dtc_ctrl.sv
module tb_halfspan_dtc_ctrl;
  localparam int INT_W = 4, FRAC_W = 6, GAIN_W = 6, DCC_W = 4, DTC_W = 5, TUNE_W = 8, KG_W = 4;
  localparam int PERIOD = 1 << FRAC_W;
  localparam int HALF   = PERIOD / 2;

  logic clk = 1'b0, rst = 1'b1, valid = 1'b0, pd_sample = 1'b0;
  logic [INT_W-1:0] fcw_int = '0;
  logic [FRAC_W-1:0] fcw_frac = '0;
  logic [GAIN_W-1:0] gain = '0;
  logic signed [DCC_W-1:0] dcc = '0;
  logic [KG_W-1:0] kp = '0, ki = '0;
  logic [INT_W:0] div_mod;
  logic swap;
  logic [DTC_W-1:0] dtc_word;
  logic signed [TUNE_W-1:0] tune_word;

  int checks = 0, fails = 0;
  int m_phase = 0, m_integ = 0, m_tune = 0, m_swap = 0;
  bit done = 0;

  always #10 clk = ~clk;

  halfspan_dtc_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .GAIN_W(GAIN_W), .DCC_W(DCC_W),
    .DTC_W(DTC_W), .TUNE_W(TUNE_W), .KG_W(KG_W)) dut (
    .clk(clk), .rst(rst), .valid(valid), .fcw_int(fcw_int), .fcw_frac(fcw_frac),
    .gain(gain), .dcc(dcc), .pd_sample(pd_sample), .kp(kp), .ki(ki),
    .div_mod(div_mod), .swap(swap), .dtc_word(dtc_word), .tune_word(tune_word));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    m_phase = 0; m_integ = 0; m_tune = 0; m_swap = 0;
    chk(div_mod == 0, "R1 div_mod", int'(div_mod), 0);
    chk(swap == 0, "R1 swap", int'(swap), 0);
    chk(dtc_word == 0, "R1 dtc_word", int'(dtc_word), 0);
    chk(tune_word == 0, "R1 tune_word", int'(tune_word), 0);
  endtask

  // one strobe; returns model carry
  task automatic strobe(output int carry);
    int sum, exp_dtc, pos, exp_mod, old_swap;
    valid = 1'b1;
    old_swap = m_swap;
    sum = m_phase + int'(fcw_frac);
    carry = (sum >= PERIOD) ? 1 : 0;
    m_phase = sum % PERIOD;
    m_swap = m_phase / HALF;
    exp_dtc = clampi(((m_phase % HALF) * int'(gain)) / HALF + int'(dcc), 0, (1 << DTC_W) - 1);
    pos = int'(pd_sample) ^ old_swap;   // R5 sign correction
    m_integ = clampi(m_integ + (pos ? int'(ki) : -int'(ki)), -(1 << (TUNE_W-1)), (1 << (TUNE_W-1)) - 1);
    m_tune  = clampi(m_integ + (pos ? int'(kp) : -int'(kp)), -(1 << (TUNE_W-1)), (1 << (TUNE_W-1)) - 1);
    exp_mod = int'(fcw_int) + carry;
    @(negedge clk);
    valid = 1'b0;
    chk(int'(div_mod) == exp_mod, "R2 div_mod", int'(div_mod), exp_mod);
    chk(int'(swap) == m_swap, "R3 swap", int'(swap), m_swap);
    chk(int'(dtc_word) == exp_dtc, "R4 dtc_word", int'(dtc_word), exp_dtc);
    chk(int'(tune_word) == m_tune, "R5/R6 tune_word", int'(tune_word), m_tune);
    if (fcw_frac == 0) begin
      chk(int'(swap) == old_swap, "R8 swap held", int'(swap), old_swap);
      chk(int'(div_mod) == int'(fcw_int), "R8 div_mod", int'(div_mod), int'(fcw_int));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int carry, csum;
    logic [INT_W:0] h_mod; logic h_swap; logic [DTC_W-1:0] h_dtc; logic signed [TUNE_W-1:0] h_tune;
    repeat (2) @(negedge clk);
    do_reset();
    for (int f = 0; f < PERIOD; f++) begin
      fcw_frac = FRAC_W'(f);
      fcw_int  = INT_W'(f % 13);
      csum = 0;
      for (int k = 0; k < PERIOD; k++) begin
        gain      = GAIN_W'((f * 7 + k * 3) % 64);
        dcc       = DCC_W'((k % 16) - 8);
        kp        = KG_W'((f + k) % 16);
        ki        = KG_W'(k % 5 + f % 11);
        pd_sample = ((k / 3) % 2 == 0) ^ (f > 40);
        strobe(carry);
        csum += carry;
        if (k % 17 == 5) begin
          // R7: idle strobe changes nothing
          h_mod = div_mod; h_swap = swap; h_dtc = dtc_word; h_tune = tune_word;
          fcw_frac = ~fcw_frac; pd_sample = ~pd_sample; ki = '1;
          @(negedge clk);
          chk(div_mod == h_mod && swap == h_swap && dtc_word == h_dtc && tune_word == h_tune,
              "R7 hold", int'(dtc_word), int'(h_dtc));
          fcw_frac = FRAC_W'(f);
        end
      end
      chk(csum == f, "R2 carries per period", csum, f);
      if (f == 31) do_reset();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule